// File: doc/BRIEF.md
# Q-Format Fractional Multiplier

This block multiplies two signed 16-bit two's-complement fixed-point operands and writes the product back in one of four storage formats. The 32-bit raw product of two fractional operands carries one redundant copy of the sign at the top. Each format first removes that copy and then takes the bit field that puts the binary point where the format wants it. The less significant bits are dropped, so every result is truncated toward negative infinity.

Two formats treat the operands as pure fractions (one sign bit, 15 fraction bits). One returns a 16-bit fraction and the other a 32-bit fraction. The other two formats treat the operands as three integer bits plus twelve fraction bits. Their 16-bit result holds either six integer bits with nine fraction bits, or the narrower three-integer / twelve-fraction layout. When the chosen field cannot hold the true product, an overflow flag is raised. A configuration input then chooses between the wrapped bit pattern and a clamp to the most positive or most negative code.

Operands, format and clamp choice are taken together on a valid/ready handshake. The result is held in a single output register. It appears on the cycle after acceptance and stays until the consumer takes it.

Top module: `qfmul_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid` is 0 after that edge; after reset `in_ready` is 1.
- R2: With `fmt` = 2'b00 (fraction in, 16-bit fraction out), `result[15:0]` is product bits [30:15] and `result[31:16]` copies `result[15]`.
- R3: With `fmt` = 2'b01 (fraction in, 32-bit fraction out), `result` is product bits [30:0] followed by a 0 in bit 0.
- R4: With `fmt` = 2'b10 (3.12 in, 3.12 out), `result[15:0]` is product bits [27:12], sign-extended to 32 bits. `ovf` is 1 when product bits [31:27] are not all equal. For example, 0x7800 × 0x7400 (7.5 × 7.25) gives 0x6600 (6.375) with `ovf` = 1.
- R5: With `fmt` = 2'b11 (3.12 in, 6.9 out), `result[15:0]` is product bits [30:15], sign-extended. 0x7800 × 0x7400 gives 0x6CC0 (54.375) with `ovf` = 0.
- R6: In formats 2'b00, 2'b01 and 2'b11, `ovf` is 1 exactly when product bits 31 and 30 differ. This happens only for 0x8000 × 0x8000, and the wrapped 16-bit fraction result is then 0xFFFF8000.
- R7: When `ovf` is 1 and `sat_en` was 1 at acceptance, the result is clamped to the format's extreme code with the sign of the true product. The 16-bit formats use 0x00007FFF or 0xFFFF8000; the 32-bit fraction uses 0x7FFFFFFF or 0x80000000. When `sat_en` was 0, the wrapped field is returned. `ovf` is reported in both cases.
- R8: A transfer is accepted when `in_valid` and `in_ready` are both 1. `out_valid` is 1 on the next cycle. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is 1 and `out_ready` is 0, `result` and `ovf` do not change.
- R9: `fmt` and `sat_en` matter only in the cycle of acceptance. Changing them, or the operands, while nothing is accepted leaves the held output unchanged.
- R10: Signs are handled fully: 0x6000 × 0xE000 (0.75 × −0.25) in format 2'b00 gives 0xFFFFE800 (−0.1875).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands offered |
| in_ready | output | 1 | Block can take operands this cycle |
| op_a | input | 16 | Multiplicand, two's complement |
| op_b | input | 16 | Multiplier, two's complement |
| fmt | input | 2 | Output format select (see R2–R5) |
| sat_en | input | 1 | Clamp on overflow when 1 |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| result | output | 32 | Formatted product, 16-bit formats sign-extended |
| ovf | output | 1 | The chosen field could not hold the product |

## Verification
The assertions assume that the consumer follows the handshake: `out_ready` may drop at any time, but results are only counted where `out_valid` and `out_ready` are both high. They also assume that `fmt`, `sat_en` and the operands are known whenever `in_valid` is high.

The stimulus changes inputs only away from the rising edge. It keeps `in_valid` low between offers, and during those gaps it scrambles format, clamp and operands so that any late sampling shows up. The random backpressure on `out_ready` holds results for several cycles, which exercises the hold rule.

// File: rtl/qfmul_pkg.sv
// Shared definitions for the Q-format multiplier.
// Assumes two's-complement operands; the format code is part of the port contract.
package qfmul_pkg;
    typedef enum logic [1:0] {
        FMT_FRAC16 = 2'b00,
        FMT_FRAC32 = 2'b01,
        FMT_I3F12  = 2'b10,
        FMT_I6F9   = 2'b11
    } qfmt_e;
endpackage

// File: rtl/qfmul_prod.sv
// Signed array product: adds shifted, sign-extended partial products.
// The partial product for the multiplier's sign bit is subtracted.
// Assumes DW >= 2; purely combinational.
module qfmul_prod #(
    parameter int DW = 16
) (
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    output logic [2*DW-1:0] prod
);
    localparam int PW = 2 * DW;

    // Accumulate one partial product per multiplier bit.
    always_comb begin
        logic [PW-1:0] acc;
        logic [PW-1:0] pp;
        acc = '0;
        for (int i = 0; i < DW; i++) begin
            pp = {{DW{a[DW-1]}}, a} << i;
            if (!b[i]) begin
                pp = '0;
            end
            if (i == DW - 1) begin
                acc = acc - pp;
            end else begin
                acc = acc + pp;
            end
        end
        prod = acc;
    end
endmodule

// File: rtl/qfmul_align.sv
// Picks the stored field for the selected format and detects overflow.
// On overflow it can clamp to the extreme code that has the true sign.
// Assumes the product is full-width: its top bit is the real sign.
module qfmul_align
    import qfmul_pkg::*;
#(
    parameter int DW      = 16,
    parameter int IF_FRAC = 12
) (
    input  logic [2*DW-1:0] prod,
    input  qfmt_e           fmt,
    input  logic            sat,
    output logic [2*DW-1:0] res,
    output logic            ovf
);
    localparam int PW      = 2 * DW;
    localparam int FR_LSB  = DW - 1;
    localparam int TOP_LSB = IF_FRAC + DW - 1;
    localparam int TOP_W   = PW - TOP_LSB;

    logic [DW-1:0]    narrow_fld;
    logic [DW-1:0]    int_fld;
    logic [PW-1:0]    wide_fld;
    logic [TOP_W-1:0] int_top;
    logic             dbl_sign_ovf;
    logic             int_ovf;
    logic             neg;
    logic [DW-1:0]    clamp_n;
    logic [PW-1:0]    clamp_w;

    // Candidate fields, overflow terms and clamp codes.
    always_comb begin
        narrow_fld   = prod[FR_LSB +: DW];
        int_fld      = prod[IF_FRAC +: DW];
        wide_fld     = {prod[PW-2:0], 1'b0};
        int_top      = prod[PW-1:TOP_LSB];
        dbl_sign_ovf = prod[PW-1] ^ prod[PW-2];
        int_ovf      = !((&int_top) || !(|int_top));
        neg          = prod[PW-1];
        clamp_n      = neg ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
        clamp_w      = neg ? {1'b1, {(PW-1){1'b0}}} : {1'b0, {(PW-1){1'b1}}};
    end

    // Format select with optional clamp.
    always_comb begin
        logic [DW-1:0] n;
        n   = narrow_fld;
        res = '0;
        ovf = 1'b0;
        unique case (fmt)
            FMT_FRAC32: begin
                ovf = dbl_sign_ovf;
                res = (ovf && sat) ? clamp_w : wide_fld;
            end
            FMT_I3F12: begin
                ovf = int_ovf;
                n   = (ovf && sat) ? clamp_n : int_fld;
                res = {{DW{n[DW-1]}}, n};
            end
            default: begin
                ovf = dbl_sign_ovf;
                n   = (ovf && sat) ? clamp_n : narrow_fld;
                res = {{DW{n[DW-1]}}, n};
            end
        endcase
    end
endmodule

// File: rtl/qfmul_oreg.sv
// Single output register with a valid/ready handshake.
// Takes new data when empty or when the held data leaves in the same cycle.
// Assumes a synchronous active-low reset.
module qfmul_oreg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] d_res,
    input  logic         d_ovf,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] q_res,
    output logic         q_ovf
);
    logic take;

    // Acceptance condition.
    always_comb begin
        in_ready = !out_valid || out_ready;
        take     = in_valid && in_ready;
    end

    // Valid flag tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else if (take) begin
            out_valid <= 1'b1;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // Data capture on acceptance only.
    always_ff @(posedge clk) begin
        if (take) begin
            q_res <= d_res;
            q_ovf <= d_ovf;
        end
    end
endmodule

// File: rtl/qfmul_top.sv
// Q-format fractional multiplier top: product, format alignment, output register.
// Assumes the format and clamp inputs are valid along with the operands.
module qfmul_top
    import qfmul_pkg::*;
#(
    parameter int DW      = 16,
    parameter int IF_FRAC = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [DW-1:0]   op_a,
    input  logic [DW-1:0]   op_b,
    input  logic [1:0]      fmt,
    input  logic            sat_en,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [2*DW-1:0] result,
    output logic            ovf
);
    localparam int PW = 2 * DW;

    logic [PW-1:0] prod;
    logic [PW-1:0] aligned;
    logic          aligned_ovf;

    qfmul_prod #(.DW(DW)) prod_i (
        .a    (op_a),
        .b    (op_b),
        .prod (prod)
    );

    qfmul_align #(.DW(DW), .IF_FRAC(IF_FRAC)) align_i (
        .prod (prod),
        .fmt  (qfmt_e'(fmt)),
        .sat  (sat_en),
        .res  (aligned),
        .ovf  (aligned_ovf)
    );

    qfmul_oreg #(.W(PW)) oreg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .d_res     (aligned),
        .d_ovf     (aligned_ovf),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .q_res     (result),
        .q_ovf     (ovf)
    );
endmodule

// File: rtl/qfmul_chk.sv
// Port-level protocol and result checks for qfmul_top, attached by bind.
// Assumes the default 16-bit operand width.
module qfmul_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic [15:0] op_a,
    input logic [15:0] op_b,
    input logic [1:0]  fmt,
    input logic        sat_en,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] result,
    input logic        ovf
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(result) && $stable(ovf));

    assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    assert_sign_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && fmt != 2'b01 |=> result[31:16] == {16{result[15]}});

    assert_corner_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && fmt == 2'b00 && op_a == 16'h8000 && op_b == 16'h8000 |=> ovf);

    assert_clamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && sat_en && fmt == 2'b01
        |=> !ovf || result == 32'h7FFF_FFFF || result == 32'h8000_0000);
endmodule

bind qfmul_top qfmul_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .op_a      (op_a),
    .op_b      (op_b),
    .fmt       (fmt),
    .sat_en    (sat_en),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .result    (result),
    .ovf       (ovf)
);

// File: tb/qfmul_top_tb_top.sv
module qfmul_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic [1:0]  fmt = '0;
    logic        sat_en = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] result;
    logic        ovf;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  bp_en = 1'b0;
    bit  done = 1'b0;
    logic [32:0] exp_q[$];
    string       tag_q[$];
    logic [32:0] held;
    bit          held_v = 1'b0;

    always #5 clk = ~clk;

    qfmul_top dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .op_a(op_a), .op_b(op_b), .fmt(fmt), .sat_en(sat_en),
        .out_valid(out_valid), .out_ready(out_ready), .result(result), .ovf(ovf)
    );

    // Expected {ovf, result} from the requirement text.
    function automatic logic [32:0] model(input logic [15:0] a, input logic [15:0] b,
                                          input logic [1:0] f, input logic s);
        logic signed [31:0] p;
        logic [15:0] n;
        logic [31:0] w;
        logic        o;
        p = $signed(a) * $signed(b);
        case (f)
            2'b01: begin
                o = p[31] ^ p[30];
                w = {p[30:0], 1'b0};
                if (o && s) w = p[31] ? 32'h8000_0000 : 32'h7FFF_FFFF;
                return {o, w};
            end
            2'b10: begin
                o = !(p[31:27] == 5'h00 || p[31:27] == 5'h1F);
                n = p[27:12];
            end
            default: begin
                o = p[31] ^ p[30];
                n = p[30:15];
            end
        endcase
        if (o && s) n = p[31] ? 16'h8000 : 16'h7FFF;
        return {o, {{16{n[15]}}, n}};
    endfunction

    function automatic string tag_of(input logic [1:0] f, input logic s, input logic o);
        if (o) return s ? "R7" : (f == 2'b10 ? "R4" : "R6");
        case (f)
            2'b00: return "R2";
            2'b01: return "R3";
            2'b10: return "R4";
            default: return "R5";
        endcase
    endfunction

    // Driver: offer one transfer, queue its expectation, then scramble idle inputs (R9).
    task automatic drive(input logic [15:0] a, input logic [15:0] b,
                         input logic [1:0] f, input logic s, input string tg);
        logic [32:0] e;
        @(negedge clk);
        op_a = a; op_b = b; fmt = f; sat_en = s; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        e = model(a, b, f, s);
        exp_q.push_back(e);
        tag_q.push_back(tg == "" ? tag_of(f, s, e[32]) : tg);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        fmt = ~f; sat_en = ~s; op_a = ~a; op_b = a ^ b;
    endtask

    // Backpressure source, changed away from both edges used elsewhere.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            out_ready = bp_en ? ($urandom_range(0, 3) != 0) : 1'b1;
        end
    end

    // Monitor: compare completed results and check holding under stall (R8).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (held_v) begin
                n_checks++;
                if (!out_valid || {ovf, result} != held) begin
                    n_fail++;
                    $display("FAIL R8 held output changed: got %b/%h exp %b/%h",
                             ovf, result, held[32], held[31:0]);
                end
            end
            held_v = out_valid && !out_ready;
            held   = {ovf, result};
            if (out_valid && out_ready) begin
                n_checks++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R8 unexpected result %h, expected none", result);
                end else begin
                    logic [32:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if ({ovf, result} != e) begin
                        n_fail++;
                        $display("FAIL %s got ovf=%b result=%h expected ovf=%b result=%h",
                                 t, ovf, result, e[32], e[31:0]);
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1_500_000;
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired, %0d results outstanding, expected 0", exp_q.size());
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            n_fail++;
            $display("FAIL R1 out_valid=%b in_ready=%b expected 0/1", out_valid, in_ready);
        end
        rst_n = 1'b1;

        drive(16'h6000, 16'hE000, 2'b00, 1'b0, "R10");
        drive(16'h8000, 16'h8000, 2'b00, 1'b0, "R6");
        drive(16'h8000, 16'h8000, 2'b00, 1'b1, "R7");
        drive(16'h8000, 16'h8000, 2'b01, 1'b0, "R6");
        drive(16'h8000, 16'h8000, 2'b01, 1'b1, "R7");
        drive(16'h7800, 16'h7400, 2'b10, 1'b0, "R4");
        drive(16'h7800, 16'h7400, 2'b10, 1'b1, "R7");
        drive(16'h8800, 16'h7400, 2'b10, 1'b1, "R7");
        drive(16'h7800, 16'h7400, 2'b11, 1'b0, "R5");
        drive(16'h8000, 16'h8000, 2'b11, 1'b0, "R6");
        drive(16'h4000, 16'h0001, 2'b01, 1'b0, "R3");
        drive(16'hFFFF, 16'h0001, 2'b00, 1'b0, "R2");

        for (int k = 0; k < 1200; k++) begin
            bp_en = (k >= 400);
            drive(16'($urandom), 16'($urandom), 2'(k % 4), 1'($urandom_range(0, 1)), "");
        end

        bp_en = 1'b0;
        for (int k = 0; k < 100 && exp_q.size() != 0; k++) @(negedge clk);
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            if (exp_q.size() != 0) begin
                n_fail++;
                $display("FAIL R8 %0d results never delivered, expected 0", exp_q.size());
            end
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule